// File: doc/BRIEF.md
# Banked Stack Pointer Register Unit

This block keeps the stack pointers of a processor core. It picks exactly one of them as the active pointer. The choice depends on the execution mode (thread or handler), a software-controlled select bit, and, when the build enables it, the current security state. The active pointer goes straight to the datapath. Explicit writes replace it. Push and pop strobes step it by one 32-bit word, and the block drives the memory address that the transfer uses.

With the security option off there are two pointers: main and process. With it on there are four: a main and a process pointer in each of the two security banks. Every pointer is word aligned. The lowest two bits are stored nowhere and always read as zero. A push moves the pointer down first and then uses the new address. A pop uses the current address and then moves the pointer up. During an exception return, the select bit carried in the return value chooses the pointer instead of the control bit. The memory, the exception stacking sequence and the instruction decoder sit outside the block.

Top module: `stack_ptr_bank`

## Requirements
- R1: After reset, each pointer holds its parameter reset value with bits [1:0] cleared. With handler_mode=0 and ctrl_sel=0, the main pointer of the bank chosen by secure_state is active.
- R2: With handler_mode=1 and exc_ret=0, the main pointer is active whatever ctrl_sel is.
- R3: In thread mode (handler_mode=0) with exc_ret=0, ctrl_sel=1 makes the process pointer active and ctrl_sel=0 makes the main pointer active.
- R4: While exc_ret=1, ret_sel alone chooses the pointer (1 = process, 0 = main), overriding ctrl_sel and handler_mode.
- R5: wr_en=1 loads the active pointer with wr_data at the next clock edge, with bits [1:0] forced to zero.
- R6: push=1 puts the active pointer minus 4 on xfer_addr in the same cycle. After the clock edge the active pointer equals that address.
- R7: pop=1 puts the active pointer itself on xfer_addr in the same cycle. After the clock edge the active pointer has grown by 4.
- R8: A write, push or pop changes only the active pointer. Every other pointer keeps its value.
- R9: Priority is write, then push, then pop. With wr_en high the strobes are ignored. With push and pop together the cycle acts as a push.
- R10: With SECURE_EN=1, secure_state=1 selects the secure bank and 0 the non-secure bank. With SECURE_EN=0, secure_state has no effect.
- R11: When no write, push or pop is requested, xfer_addr equals the active pointer and no pointer changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| handler_mode | input | 1 | 1 = handler (exception) mode, 0 = thread mode |
| ctrl_sel | input | 1 | Software select bit: 1 = process pointer in thread mode |
| secure_state | input | 1 | Current security state; used only when SECURE_EN=1 |
| exc_ret | input | 1 | Exception return in progress this cycle |
| ret_sel | input | 1 | Select bit taken from the exception return value |
| wr_en | input | 1 | Write the active pointer |
| wr_data | input | AW | Value written; bits [1:0] are dropped |
| push | input | 1 | Push strobe: pre-decrement by 4 |
| pop | input | 1 | Pop strobe: post-increment by 4 |
| sp_active | output | AW | Currently active stack pointer |
| xfer_addr | output | AW | Memory address of the current stack transfer |

## Verification
A wrong bank index shows on sp_active in the same cycle, because the pointer is chosen combinationally from mode, select bit, return select and security state. A wrong step or a wrong write target shows on sp_active one edge later. A write or step that corrupted an inactive pointer stays hidden until the controls switch to that pointer. The tests therefore switch back to every bank they did not touch and compare its value. An address taken before instead of after the decrement shows on xfer_addr in the cycle of the strobe.

// File: rtl/spb_pkg.sv
package spb_pkg;
  // stack transfer size in bytes; pointers move in whole words
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned ALIGN_BITS = 2;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_WRITE = 2'd1,
    OP_PUSH  = 2'd2,
    OP_POP   = 2'd3
  } spb_op_e;
endpackage

// File: rtl/spb_select.sv
module spb_select #(
  parameter bit          SECURE_EN = 1'b0,
  parameter int unsigned IDX_W     = 1
) (
  input  logic             handler_mode,
  input  logic             ctrl_sel,
  input  logic             secure_state,
  input  logic             exc_ret,
  input  logic             ret_sel,
  output logic [IDX_W-1:0] idx
);
  logic use_proc;

  // process pointer only from thread mode; return value overrides
  always_comb begin
    if (exc_ret) use_proc = ret_sel;
    else         use_proc = ~handler_mode & ctrl_sel;
  end

  generate
    if (SECURE_EN) begin : g_four
      assign idx = {secure_state, use_proc};
    end else begin : g_two
      logic unused_sec;
      assign unused_sec = secure_state;
      assign idx = use_proc;
    end
  endgenerate
endmodule

// File: rtl/spb_next.sv
module spb_next
  import spb_pkg::*;
#(
  parameter int unsigned AW = 32,
  localparam int unsigned WW = AW - ALIGN_BITS
) (
  input  logic [WW-1:0] cur_word,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  input  logic          push,
  input  logic          pop,
  output logic          load,
  output logic [WW-1:0] next_word,
  output logic [WW-1:0] addr_word
);
  spb_op_e op;
  logic    unused_low;

  assign unused_low = ^wr_data[ALIGN_BITS-1:0];

  always_comb begin
    if (wr_en)     op = OP_WRITE;
    else if (push) op = OP_PUSH;
    else if (pop)  op = OP_POP;
    else           op = OP_HOLD;
  end

  always_comb begin
    next_word = cur_word;
    addr_word = cur_word;
    unique case (op)
      OP_WRITE: next_word = wr_data[AW-1:ALIGN_BITS];
      OP_PUSH: begin
        next_word = cur_word - WW'(1);
        addr_word = cur_word - WW'(1);
      end
      OP_POP:   next_word = cur_word + WW'(1);
      default:  next_word = cur_word;
    endcase
  end

  assign load = (op != OP_HOLD);
endmodule

// File: rtl/spb_regs.sv
module spb_regs
  import spb_pkg::*;
#(
  parameter int unsigned AW          = 32,
  parameter int unsigned IDX_W       = 1,
  parameter logic [AW-1:0] RST_MAIN_NS = '0,
  parameter logic [AW-1:0] RST_PROC_NS = '0,
  parameter logic [AW-1:0] RST_MAIN_S  = '0,
  parameter logic [AW-1:0] RST_PROC_S  = '0,
  localparam int unsigned WW  = AW - ALIGN_BITS,
  localparam int unsigned NUM = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             load,
  input  logic [WW-1:0]    next_word,
  output logic [WW-1:0]    cur_word
);
  logic [WW-1:0] bank_q [NUM];

  generate
    for (genvar i = 0; i < NUM; i++) begin : g_sp
      localparam logic [AW-1:0] RV = (i == 0) ? RST_MAIN_NS :
                                     (i == 1) ? RST_PROC_NS :
                                     (i == 2) ? RST_MAIN_S  : RST_PROC_S;
      logic          en;
      logic [WW-1:0] d;

      assign en = load && (idx == IDX_W'(i));
      always_comb d = en ? next_word : bank_q[i];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q[i] <= RV[AW-1:ALIGN_BITS];
        else        bank_q[i] <= d;
      end

      // R8: a pointer not selected keeps its value across any operation
      a_r8_inactive_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (idx != IDX_W'(i)) |=> $stable(bank_q[i]));
    end
  endgenerate

  assign cur_word = bank_q[idx];
endmodule

// File: rtl/stack_ptr_bank.sv
module stack_ptr_bank
  import spb_pkg::*;
#(
  parameter int unsigned   AW          = 32,
  parameter bit            SECURE_EN   = 1'b0,
  parameter logic [AW-1:0] RST_MAIN_NS = 32'h2000_8000,
  parameter logic [AW-1:0] RST_PROC_NS = 32'h2000_4000,
  parameter logic [AW-1:0] RST_MAIN_S  = 32'h3000_8000,
  parameter logic [AW-1:0] RST_PROC_S  = 32'h3000_4000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          handler_mode,
  input  logic          ctrl_sel,
  input  logic          secure_state,
  input  logic          exc_ret,
  input  logic          ret_sel,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] sp_active,
  output logic [AW-1:0] xfer_addr
);
  localparam int unsigned IDX_W = SECURE_EN ? 2 : 1;
  localparam int unsigned WW    = AW - ALIGN_BITS;
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  logic             rst_meta_q, rst_sync_n;
  logic [IDX_W-1:0] idx;
  logic             load;
  logic [WW-1:0]    cur_word, next_word, addr_word;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  spb_select #(.SECURE_EN(SECURE_EN), .IDX_W(IDX_W)) u_sel (
    .handler_mode (handler_mode),
    .ctrl_sel     (ctrl_sel),
    .secure_state (secure_state),
    .exc_ret      (exc_ret),
    .ret_sel      (ret_sel),
    .idx          (idx)
  );

  spb_next #(.AW(AW)) u_next (
    .cur_word  (cur_word),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .push      (push),
    .pop       (pop),
    .load      (load),
    .next_word (next_word),
    .addr_word (addr_word)
  );

  spb_regs #(
    .AW(AW), .IDX_W(IDX_W),
    .RST_MAIN_NS(RST_MAIN_NS), .RST_PROC_NS(RST_PROC_NS),
    .RST_MAIN_S(RST_MAIN_S),   .RST_PROC_S(RST_PROC_S)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .idx       (idx),
    .load      (load),
    .next_word (next_word),
    .cur_word  (cur_word)
  );

  assign sp_active = {cur_word,  {ALIGN_BITS{1'b0}}};
  assign xfer_addr = {addr_word, {ALIGN_BITS{1'b0}}};

  // R6: push address is the decremented pointer, which becomes the new pointer
  a_r6_push_predec: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (push && !wr_en) |=> (idx != $past(idx)) ||
      ((sp_active == $past(sp_active) - STEP) && (sp_active == $past(xfer_addr))));

  // R7: pop address is the old pointer, pointer then grows by one word
  a_r7_pop_postinc: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pop && !push && !wr_en) |=> (idx != $past(idx)) ||
      ((sp_active == $past(xfer_addr) + STEP) && ($past(xfer_addr) == $past(sp_active))));

  // R5, R9: a write wins over strobes and lands word aligned
  a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |=> (idx != $past(idx)) ||
      (sp_active == {$past(wr_data[AW-1:ALIGN_BITS]), {ALIGN_BITS{1'b0}}}));

  // R11: idle cycle leaves the selected pointer and address alone
  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_en && !push && !pop) |-> (xfer_addr == sp_active) ##1
      ((idx != $past(idx)) || $stable(sp_active)));
endmodule

// File: tb/sim_stack_ptr_bank.sv
`timescale 1ns/100ps
module sim_stack_ptr_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        handler_mode, ctrl_sel, secure_state, exc_ret, ret_sel;
  logic        wr_en, push, pop;
  logic [31:0] wr_data;
  logic [31:0] sp0, xa0, sp1, xa1;
  int          n_chk = 0;
  int          n_err = 0;

  always #2.5 clk = ~clk;

  stack_ptr_bank #(
    .AW(32), .SECURE_EN(1'b1),
    .RST_MAIN_NS(32'h2000_8000), .RST_PROC_NS(32'h2000_4000),
    .RST_MAIN_S(32'h3000_8002),  .RST_PROC_S(32'h3000_4000)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .handler_mode(handler_mode), .ctrl_sel(ctrl_sel),
    .secure_state(secure_state), .exc_ret(exc_ret), .ret_sel(ret_sel),
    .wr_en(wr_en), .wr_data(wr_data), .push(push), .pop(pop),
    .sp_active(sp0), .xfer_addr(xa0)
  );

  stack_ptr_bank #(.AW(32), .SECURE_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .handler_mode(handler_mode), .ctrl_sel(ctrl_sel),
    .secure_state(secure_state), .exc_ret(exc_ret), .ret_sel(ret_sel),
    .wr_en(wr_en), .wr_data(wr_data), .push(push), .pop(pop),
    .sp_active(sp1), .xfer_addr(xa1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // set controls after a falling edge, settle, no strobes
  task automatic ctl(input logic hm, input logic cs, input logic sec,
                     input logic er, input logic rs);
    @(negedge clk);
    handler_mode = hm; ctrl_sel = cs; secure_state = sec;
    exc_ret = er; ret_sel = rs;
    wr_en = 1'b0; push = 1'b0; pop = 1'b0;
    #1;
  endtask

  // finish the current cycle with a clock edge, then drop strobes
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; push = 1'b0; pop = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    ctl(0, 0, 0, 0, 0);
    chk("R1 main ns reset", sp0, 32'h2000_8000);
    chk("R11 idle address", xa0, 32'h2000_8000);
    chk("R1 two-pointer build reset", sp1, 32'h2000_8000);
    ctl(0, 0, 1, 0, 0);
    chk("R1 main s reset low bits cleared", sp0, 32'h3000_8000);
  endtask

  task automatic t_select();
    ctl(0, 1, 0, 0, 0);
    chk("R3 thread sel=1 process", sp0, 32'h2000_4000);
    ctl(1, 1, 0, 0, 0);
    chk("R2 handler forces main", sp0, 32'h2000_8000);
    chk("R2 handler forces main two-pointer", sp1, 32'h2000_8000);
    ctl(0, 1, 1, 0, 0);
    chk("R10 secure process", sp0, 32'h3000_4000);
    chk("R10 security ignored when off", sp1, 32'h2000_4000);
    ctl(0, 0, 1, 0, 0);
    chk("R3 thread sel=0 main", sp0, 32'h3000_8000);
  endtask

  task automatic t_exc_ret();
    ctl(1, 0, 0, 1, 1);
    chk("R4 return selects process", sp0, 32'h2000_4000);
    ctl(0, 1, 0, 1, 0);
    chk("R4 return selects main", sp0, 32'h2000_8000);
  endtask

  task automatic t_push_pop();
    ctl(0, 1, 0, 0, 0);
    push = 1'b1; #1;
    chk("R6 push address", xa0, 32'h2000_3FFC);
    tick();
    chk("R6 pointer after push", sp0, 32'h2000_3FFC);
    push = 1'b1; #1;
    chk("R6 second push address", xa0, 32'h2000_3FF8);
    tick();
    pop = 1'b1; #1;
    chk("R7 pop address", xa0, 32'h2000_3FF8);
    tick();
    chk("R7 pointer after pop", sp0, 32'h2000_3FFC);
    ctl(0, 0, 0, 0, 0);
    chk("R8 main untouched by push/pop", sp0, 32'h2000_8000);
    ctl(0, 1, 0, 0, 0);
    pop = 1'b1; #1;
    tick();
    chk("R7 back to start", sp0, 32'h2000_4000);
  endtask

  task automatic t_write();
    ctl(1, 1, 1, 0, 0);
    wr_en = 1'b1; wr_data = 32'h1234_5677; #1;
    tick();
    chk("R5 write aligned", sp0, 32'h1234_5674);
    chk("R5 write aligned two-pointer", sp1, 32'h1234_5674);
    ctl(0, 1, 1, 0, 0);
    chk("R8 secure process untouched", sp0, 32'h3000_4000);
    ctl(0, 0, 0, 0, 0);
    chk("R8 non-secure main untouched", sp0, 32'h2000_8000);
  endtask

  task automatic t_priority();
    ctl(0, 1, 1, 0, 0);
    wr_en = 1'b1; push = 1'b1; pop = 1'b1; wr_data = 32'h3000_1001; #1;
    chk("R9 write cycle address unmoved", xa0, 32'h3000_4000);
    tick();
    chk("R9 write beats strobes", sp0, 32'h3000_1000);
    push = 1'b1; pop = 1'b1; #1;
    chk("R9 push beats pop address", xa0, 32'h3000_0FFC);
    tick();
    chk("R9 push beats pop pointer", sp0, 32'h3000_0FFC);
    tick();
    chk("R11 idle holds", sp0, 32'h3000_0FFC);
  endtask

  initial begin
    #(5 * 100000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    handler_mode = 1'b0; ctrl_sel = 1'b0; secure_state = 1'b0;
    exc_ret = 1'b0; ret_sel = 1'b0;
    wr_en = 1'b0; push = 1'b0; pop = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_select();
    t_exc_ret();
    t_push_pop();
    t_write();
    t_priority();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule